// File: doc/BRIEF.md
# Polled Console Register Block

This block gives a processor a byte-wide console through four word registers that sit in a 16-byte window at the top of the address space. The receive side catches bytes from a keyboard source. The transmit side hands bytes to a display sink. Each side has a status word whose bit 0 is a Ready flag, and a data word.

Software spins on a status word until Ready reads 1. It then loads the receive data word or stores to the transmit data word. The bus is single-cycle: read data is combinational in the cycle of the access, and register updates take effect at the clock edge that ends the access.

The receive Ready flag is raised by the keyboard side and dropped by a processor load of the receive data word. The transmit Ready flag is dropped by an accepted store and comes back after a parameterised number of cycles, which models a slow display.

Top module: `conpoll_top`

## Requirements
- R1: An access is claimed (`bus_hit`=1) only when `bus_sel` is 1 and `bus_addr[31:4]` equals `BASE_ADDR[31:4]` (default 0xFFFF0000). Unclaimed accesses return 0 on `bus_rdata` and change no state.
- R2: After reset, the receive Ready flag is 0, the transmit Ready flag is 1 and `disp_valid` is 0.
- R3: A load from word offset 0 (`bus_addr[3:2]`=0) returns the receive Ready flag in bit 0. Bits 31:1 read as 0.
- R4: A cycle with `kbd_valid`=1 stores `kbd_byte` and sets receive Ready at the next edge. A load from offset 4 returns that byte in bits 7:0, with bits 31:8 equal to 0.
- R5: A load from offset 4 clears receive Ready at the edge that ends the access. If `kbd_valid` is 1 in the same cycle, the new byte is kept and Ready stays 1.
- R6: A keyboard byte that arrives while receive Ready is 1 replaces the held byte, and Ready stays 1.
- R7: A load from offset 8 returns the transmit Ready flag in bit 0. Bits 31:1 read as 0.
- R8: A store to offset 12 while transmit Ready is 1 is accepted. In the next cycle only, `disp_valid` is 1 and `disp_byte` equals `bus_wdata[7:0]`. Transmit Ready is 0 from that edge on.
- R9: Transmit Ready returns to 1 exactly `TX_BUSY_CYCLES` clock edges after the edge that accepted the store.
- R10: A store to offset 12 while transmit Ready is 0 is dropped. It produces no strobe and does not extend the busy time.
- R11: Stores to offsets 0, 4 and 8 have no effect. A load from offset 12 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Load data, valid in the access cycle |
| bus_hit | output | 1 | Access falls inside the register window |
| kbd_valid | input | 1 | Keyboard byte present this cycle |
| kbd_byte | input | BYTE_W | Keyboard byte |
| disp_valid | output | 1 | One-cycle strobe for a byte sent to the display |
| disp_byte | output | BYTE_W | Byte sent to the display |

## Verification
Several rules are checked by the assertions on every cycle:
- the display strobe follows every accepted store with the stored byte and never lasts two cycles;
- the strobe coincides with a cleared transmit Ready;
- keyboard input always raises receive Ready;
- a data load without keyboard input drops it;
- unclaimed accesses read zero, and status words carry only bit 0.

Only the bench's scenarios can show the following:
- the exact length of the transmit busy window;
- that stores during that window are dropped;
- that overwritten keyboard bytes read back as the newest one;
- that stores to status and receive-data words leave the readable state unchanged.

// File: rtl/conpoll_pkg.sv
package conpoll_pkg;

  typedef enum logic [1:0] {
    REG_RX_STAT = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_STAT = 2'd2,
    REG_TX_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    logic     rd;
    logic     wr;
    reg_sel_e sel;
  } bus_dec_t;

endpackage

// File: rtl/conpoll_decode.sv
module conpoll_decode
  import conpoll_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]     BASE_ADDR = 32'hFFFF_0000,
  parameter int unsigned           WIN_BITS  = 4
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output bus_dec_t          dec
);
  localparam int unsigned TAG_LSB = WIN_BITS;

  logic tag_match;

  always_comb begin
    tag_match = (addr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]);
    dec.hit   = sel & tag_match;
    dec.rd    = sel & tag_match & ~we;
    dec.wr    = sel & tag_match & we;
    dec.sel   = reg_sel_e'(addr[TAG_LSB-1:2]);
  end

endmodule

// File: rtl/conpoll_rx.sv
module conpoll_rx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              take,
  output logic              rdy,
  output logic [BYTE_W-1:0] held
);
  logic              rdy_d;
  logic [BYTE_W-1:0] held_d;
  logic              held_en;

  // Arriving byte wins over a same-cycle read.
  always_comb begin
    rdy_d   = rdy;
    held_d  = held;
    held_en = in_valid;
    if (in_valid) begin
      rdy_d  = 1'b1;
      held_d = in_byte;
    end else if (take) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      held <= '0;
    end else begin
      rdy <= rdy_d;
      if (held_en) held <= held_d;
    end
  end

endmodule

// File: rtl/conpoll_tx.sv
module conpoll_tx #(
  parameter int unsigned BYTE_W         = 8,
  parameter int unsigned TX_BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [BYTE_W-1:0] put_byte,
  output logic              rdy,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int unsigned BUSY_EFF = (TX_BUSY_CYCLES < 1) ? 1 : TX_BUSY_CYCLES;
  localparam int unsigned CNT_W    = $clog2(BUSY_EFF + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_EFF);

  logic [CNT_W-1:0]  cnt, cnt_d;
  logic              accept;
  logic              valid_d;
  logic              byte_en;

  assign rdy = (cnt == '0);

  always_comb begin
    accept  = put & rdy;
    valid_d = accept;
    byte_en = accept;
    cnt_d   = cnt;
    if (accept)          cnt_d = CNT_LOAD;
    else if (cnt != '0)  cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      cnt       <= cnt_d;
      out_valid <= valid_d;
      if (byte_en) out_byte <= put_byte;
    end
  end

endmodule

// File: rtl/conpoll_rdmux.sv
module conpoll_rdmux
  import conpoll_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  bus_dec_t          dec,
  input  logic              rx_rdy,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_rdy,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (dec.rd) begin
      unique case (dec.sel)
        REG_RX_STAT: rdata = DATA_W'(rx_rdy);
        REG_RX_DATA: rdata = DATA_W'(rx_byte);
        REG_TX_STAT: rdata = DATA_W'(tx_rdy);
        REG_TX_DATA: rdata = '0;
        default:     rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/conpoll_top.sv
module conpoll_top
  import conpoll_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 32,
  parameter int unsigned       DATA_W         = 32,
  parameter int unsigned       BYTE_W         = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR      = 32'hFFFF_0000,
  parameter int unsigned       TX_BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_hit,
  input  logic              kbd_valid,
  input  logic [BYTE_W-1:0] kbd_byte,
  output logic              disp_valid,
  output logic [BYTE_W-1:0] disp_byte
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;
  bus_dec_t              dec;
  logic                  rx_take, rx_rdy, tx_put, tx_rdy;
  logic [BYTE_W-1:0]     rx_byte;

  // Reset asserts at once, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  conpoll_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_BITS(4)
  ) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .dec(dec)
  );

  assign bus_hit = dec.hit;
  assign rx_take = dec.rd & (dec.sel == REG_RX_DATA);
  assign tx_put  = dec.wr & (dec.sel == REG_TX_DATA);

  conpoll_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(kbd_valid), .in_byte(kbd_byte),
    .take(rx_take), .rdy(rx_rdy), .held(rx_byte)
  );

  conpoll_tx #(.BYTE_W(BYTE_W), .TX_BUSY_CYCLES(TX_BUSY_CYCLES)) u_tx (
    .clk(clk), .rst_n(rst_sync_n),
    .put(tx_put), .put_byte(bus_wdata[BYTE_W-1:0]),
    .rdy(tx_rdy), .out_valid(disp_valid), .out_byte(disp_byte)
  );

  conpoll_rdmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mux (
    .dec(dec), .rx_rdy(rx_rdy), .rx_byte(rx_byte),
    .tx_rdy(tx_rdy), .rdata(bus_rdata)
  );

endmodule

// File: rtl/conpoll_chk.sv
module conpoll_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_hit,
  input logic              kbd_valid,
  input logic              disp_valid,
  input logic [BYTE_W-1:0] disp_byte,
  input logic              rx_rdy,
  input logic              tx_rdy
);
  logic in_win, ld, st;
  assign in_win = bus_sel && (bus_addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign ld     = in_win && !bus_we;
  assign st     = in_win && bus_we;

  // R1
  a_r1_unclaimed_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_hit |-> (bus_rdata == '0));

  // R3
  a_r3_rx_stat_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld && bus_addr[3:2] == 2'd0) |-> (bus_rdata[DATA_W-1:1] == '0));

  // R4
  a_r4_kbd_sets_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kbd_valid |=> rx_rdy);

  // R5
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld && bus_addr[3:2] == 2'd1 && !kbd_valid) |=> !rx_rdy);

  // R7
  a_r7_tx_stat_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld && bus_addr[3:2] == 2'd2) |-> (bus_rdata[DATA_W-1:1] == '0));

  // R8
  a_r8_strobe_follows_store: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st && bus_addr[3:2] == 2'd3 && tx_rdy) |=>
      (disp_valid && disp_byte == $past(bus_wdata[BYTE_W-1:0])));

  // R8
  a_r8_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disp_valid |=> !disp_valid);

  // R9
  a_r9_busy_while_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disp_valid |-> !tx_rdy);

endmodule

bind conpoll_top conpoll_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
  .kbd_valid(kbd_valid), .disp_valid(disp_valid), .disp_byte(disp_byte),
  .rx_rdy(rx_rdy), .tx_rdy(tx_rdy)
);

// File: tb/conpoll_top_test.sv
module conpoll_top_test;
  localparam int BUSY = 4;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we, bus_hit;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        kbd_valid, disp_valid;
  logic [7:0]  kbd_byte, disp_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  conpoll_top #(.TX_BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_hit(bus_hit), .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
    .disp_valid(disp_valid), .disp_byte(disp_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: each display strobe pops one expected byte.
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected strobe actual=%h expected=none", disp_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (disp_byte !== e) begin
          n_fail++;
          $display("FAIL R8 display byte actual=%h expected=%h", disp_byte, e);
        end
      end
    end
  end

  // All tasks are entered just after a falling edge and return at one.
  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic h);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata; h = bus_hit;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  // Driver for stores expected to reach the display.
  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    wr(BASE + 12, {24'hABCDEF, b});
  endtask

  task automatic key(input logic [7:0] b);
    kbd_valid = 1; kbd_byte = b;
    @(negedge clk); kbd_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic h;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    kbd_valid = 0; kbd_byte = 0;
    idle(3); rst_n = 1; idle(4);

    // R2 reset state
    chk("R2 disp_valid", {31'd0, disp_valid}, 0);
    rd(BASE + 0, d, h);  chk("R2 rx ready after reset", d, 0);
    rd(BASE + 8, d, h);  chk("R2 tx ready after reset", d, 1);
    chk("R1 hit inside window", {31'd0, h}, 1);

    // R1 outside window
    rd(32'hFFFE_FFFC, d, h); chk("R1 below window hit", {31'd0, h}, 0);
    chk("R1 below window data", d, 0);
    rd(32'hFFFF_0010, d, h); chk("R1 above window hit", {31'd0, h}, 0);
    wr(32'h0000_000C, 32'h55);
    rd(BASE + 8, d, h); chk("R1 stray store leaves tx ready", d, 1);

    // R4/R3 receive path
    key(8'hA5);
    rd(BASE + 0, d, h); chk("R3 rx ready set", d, 1);
    rd(BASE + 4, d, h); chk("R4 rx byte zero-extended", d, 32'h0000_00A5);
    rd(BASE + 0, d, h); chk("R5 rx ready cleared by read", d, 0);

    // R6 overwrite
    key(8'h11); key(8'h22);
    rd(BASE + 0, d, h); chk("R6 ready stays set", d, 1);
    rd(BASE + 4, d, h); chk("R6 newest byte kept", d, 32'h22);

    // R5 read and arrival in the same cycle
    key(8'h33);
    bus_sel = 1; bus_we = 0; bus_addr = BASE + 4; kbd_valid = 1; kbd_byte = 8'h44;
    #1 chk("R5 read sees old byte", bus_rdata, 32'h33);
    @(negedge clk); bus_sel = 0; kbd_valid = 0;
    rd(BASE + 0, d, h); chk("R5 arrival wins over clear", d, 1);
    rd(BASE + 4, d, h); chk("R5 new byte kept", d, 32'h44);

    // R11 stores to status and rx data are ignored
    key(8'h66);
    wr(BASE + 0, 32'h0);
    wr(BASE + 4, 32'h99);
    rd(BASE + 0, d, h); chk("R11 rx status store ignored", d, 1);
    rd(BASE + 4, d, h); chk("R11 rx data store ignored", d, 32'h66);
    wr(BASE + 8, 32'h0);
    rd(BASE + 8, d, h); chk("R11 tx status store ignored", d, 1);
    rd(BASE + 12, d, h); chk("R11 tx data reads zero", d, 0);

    // R8/R9/R10 transmit: store, a dropped store, then count ready-back
    send(8'h5A);
    wr(BASE + 12, 32'h0000_00EE);           // busy: dropped (R10)
    for (int j = 2; j <= BUSY; j++) begin
      rd(BASE + 8, d, h); chk("R9 tx busy", d, 0);
    end
    rd(BASE + 8, d, h); chk("R9 tx ready after busy window", d, 1);
    rd(BASE + 8, d, h); chk("R7 tx ready holds", d, 1);

    // R9 exact window without extra stores
    send(8'hC3);
    for (int j = 1; j <= BUSY; j++) begin
      rd(BASE + 8, d, h); chk("R9 tx busy window", d, 0);
    end
    rd(BASE + 8, d, h); chk("R9 ready at window end", d, 1);

    // back-to-back polled sends
    for (int k = 0; k < 3; k++) begin
      send(8'h70 + 8'(k));
      idle(BUSY);
    end
    idle(4);
    chk("R8 all display bytes seen", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule